// File: doc/BRIEF.md
# Crystal Oscillator Start-up Controller with Frequency Meter

This block manages a crystal oscillator from a slow reference clock. Software sets an enable bit, and the block waits through a programmable settling delay counted in slow cycles. The delay is the programmed unit count times eight. When the wait ends, the block raises a stable flag. That flag can drive an interrupt line through a mask bit. The analog oscillator lies outside the block and appears only as a free-running main clock input.

Once the oscillator is stable, the block measures the main clock without further software action. It opens a window sixteen slow cycles long and counts main clock rising edges inside that window. The count is held in the main domain and handed to the slow domain with a toggle handshake, so a read never sees a half-updated value. The count is then published together with a ready flag.

All registers sit on a plain single-cycle write/read bus in the slow clock domain. Read data is combinational from the address. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `xosc_ctrl`

## Requirements
- R1: After reset every readable field is zero and `irq` is low.
- R2: Register CTRL (address 0) holds enable in bit 0 and the delay units in bits 15:8. A write that takes enable from 0 to 1 at slow edge k sets the stable flag (STAT bit 0, address 2) at edge k+8·units, and not before. For units=7 that is edge k+56.
- R3: With units=0 the stable flag is set at edge k+1.
- R4: `irq` is high exactly while the stable flag and the interrupt mask (IEN bit 0, address 1) are both set.
- R5: The 16-cycle window opens on the first slow edge after the stable flag sets. The ready flag (STAT bit 1, FREQ bit 16) is therefore still low 17 slow cycles after the stable flag sets, and it rises within the 8 cycles that follow.
- R6: The count (FREQ bits 15:0, address 3) equals the number of main clock rising edges within 16 slow cycles.
- R7: The count reads as zero while the ready flag is low.
- R8: A CTRL write with enable=0 clears the stable flag, the ready flag and the count at the same edge. A new enable then runs a fresh start-up and measurement, and a stale handshake from an aborted window is ignored.
- R9: A CTRL write with enable=1 while already enabled does not restart the sequence: the stable flag, the ready flag and the count are kept.
- R10: CTRL and IEN read back as written. Writes to STAT and FREQ have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Slow reference clock |
| main_clk | input | 1 | Free-running oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on ref_clk |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Stable interrupt |

## Verification
The stable flag is due exactly 8·units slow edges after the enabling write. The bench counts those edges one by one and reads STAT one edge early and again on the due edge. The ready flag depends on the synchronizer phase, so its timing is bounded: the bench confirms it is still low 17 edges after the stable flag and then polls for at most 8 more. The count is checked against 16 slow periods divided by the main period, with the two clocks phased so that no edges coincide. Disable, re-enable and writes to read-only addresses are all judged by reading the registers just after the edge of the write.

// File: rtl/xosc_pkg.sv
package xosc_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_FREQ = 2'd3;
  typedef enum logic [1:0] {M_IDLE, M_WIN, M_WAIT, M_DONE} meas_e;
endpackage

// File: rtl/xosc_sync.sv
module xosc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d;
  end
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/xosc_startup.sv
module xosc_startup #(
  parameter int UNIT_W     = 8,
  parameter int SCALE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [UNIT_W-1:0] units,
  output logic              stable
);
  localparam int CW = UNIT_W + SCALE_LOG2;
  logic [CW-1:0] remain;
  logic          running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      running <= 1'b0;
      stable  <= 1'b0;
    end else if (stop) begin
      remain  <= '0;
      running <= 1'b0;
      stable  <= 1'b0;
    end else if (start) begin
      remain  <= {units, {SCALE_LOG2{1'b0}}};
      running <= 1'b1;
      stable  <= 1'b0;
    end else if (running) begin
      if (remain <= CW'(1)) begin
        remain  <= '0;
        running <= 1'b0;
        stable  <= 1'b1;
      end else begin
        remain <= remain - CW'(1);
      end
    end
  end
endmodule

// File: rtl/xosc_meter_main.sv
module xosc_meter_main #(
  parameter int CNT_W = 16
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             win_s,
  output logic [CNT_W-1:0] hold,
  output logic             done_tgl
);
  logic [CNT_W-1:0] cnt;
  logic             win_d;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      win_d    <= 1'b0;
      hold     <= '0;
      done_tgl <= 1'b0;
    end else begin
      win_d <= win_s;
      if (win_s) begin
        cnt <= cnt + CNT_W'(1);
      end else if (win_d) begin
        hold     <= cnt;
        done_tgl <= ~done_tgl;
        cnt      <= '0;
      end
    end
  end
endmodule

// File: rtl/xosc_meter_ref.sv
module xosc_meter_ref
  import xosc_pkg::*;
#(
  parameter int WIN   = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             stable,
  input  logic             tgl_s,
  input  logic [CNT_W-1:0] hold,
  output logic             win,
  output logic             ready,
  output logic [CNT_W-1:0] result
);
  localparam int WW = $clog2(WIN);
  meas_e         phase;
  logic [WW-1:0] wleft;
  logic          tgl_d;
  logic          tgl_edge;

  assign tgl_edge = tgl_s ^ tgl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= M_IDLE;
      wleft  <= '0;
      tgl_d  <= 1'b0;
      win    <= 1'b0;
      ready  <= 1'b0;
      result <= '0;
    end else begin
      tgl_d <= tgl_s;
      if (clear) begin
        phase  <= M_IDLE;
        wleft  <= '0;
        win    <= 1'b0;
        ready  <= 1'b0;
        result <= '0;
      end else begin
        unique case (phase)
          M_IDLE: if (stable) begin
            phase <= M_WIN;
            win   <= 1'b1;
            wleft <= WW'(WIN - 1);
          end
          M_WIN: if (wleft == '0) begin
            phase <= M_WAIT;
            win   <= 1'b0;
          end else begin
            wleft <= wleft - WW'(1);
          end
          M_WAIT: if (tgl_edge) begin
            phase  <= M_DONE;
            ready  <= 1'b1;
            result <= hold;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xosc_ctrl.sv
module xosc_ctrl
  import xosc_pkg::*;
#(
  parameter int UNIT_W     = 8,
  parameter int SCALE_LOG2 = 3,
  parameter int WIN        = 16,
  parameter int CNT_W      = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic              ref_clk,
  input  logic              main_clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int UNIT_LSB = 8;

  logic              en_q, ien_q;
  logic [UNIT_W-1:0] units_q;
  logic              wr_ctrl, start, stop, clear;
  logic              stable, win, ready;
  logic              win_s, tgl, tgl_s;
  logic [CNT_W-1:0]  hold, freq_q;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign start   = wr_ctrl && bus_wdata[0] && !en_q;
  assign stop    = wr_ctrl && !bus_wdata[0];
  assign clear   = stop || !en_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ien_q   <= 1'b0;
      units_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= bus_wdata[0];
        units_q <= bus_wdata[UNIT_LSB +: UNIT_W];
      end
      if (bus_wr && bus_addr == A_IEN) ien_q <= bus_wdata[0];
    end
  end

  xosc_startup #(.UNIT_W(UNIT_W), .SCALE_LOG2(SCALE_LOG2)) u_start (
    .clk(ref_clk), .rst_n(rst_n), .start(start), .stop(stop),
    .units(bus_wdata[UNIT_LSB +: UNIT_W]), .stable(stable)
  );

  xosc_sync #(.STAGES(SYNC_STG)) u_win_sync (
    .clk(main_clk), .rst_n(rst_n), .d(win), .q(win_s)
  );

  xosc_meter_main #(.CNT_W(CNT_W)) u_main (
    .mclk(main_clk), .rst_n(rst_n), .win_s(win_s), .hold(hold), .done_tgl(tgl)
  );

  xosc_sync #(.STAGES(SYNC_STG)) u_tgl_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(tgl), .q(tgl_s)
  );

  xosc_meter_ref #(.WIN(WIN), .CNT_W(CNT_W)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .clear(clear), .stable(stable),
    .tgl_s(tgl_s), .hold(hold), .win(win), .ready(ready), .result(freq_q)
  );

  assign irq = stable & ien_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[0] = en_q;
        bus_rdata[UNIT_LSB +: UNIT_W] = units_q;
      end
      A_IEN:  bus_rdata[0] = ien_q;
      A_STAT: bus_rdata[1:0] = {ready, stable};
      default: begin
        bus_rdata[CNT_W-1:0] = freq_q;
        bus_rdata[CNT_W]     = ready;
      end
    endcase
  end
endmodule

// File: rtl/xosc_ctrl_chk.sv
module xosc_ctrl_chk #(
  parameter int WIN   = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             ien_q,
  input logic             stable,
  input logic             win,
  input logic             ready,
  input logic             irq,
  input logic [CNT_W-1:0] freq_q
);
  int unsigned win_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   win_run <= 0;
    else if (win) win_run <= win_run + 1;
    else          win_run <= 0;
  end

  a_r2_stable_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(en_q));
  a_r4_irq_on_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (stable && ien_q) |-> irq);
  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stable |-> !irq);
  a_r5_win_after_stable: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> stable);
  a_r5_win_length: assert property (@(posedge clk) disable iff (!rst_n)
    win_run <= WIN);
  a_r5_ready_after_win: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !win && $past(!win));
  a_r7_count_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> freq_q == '0);
  a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !stable && !ready);
endmodule

bind xosc_ctrl xosc_ctrl_chk #(.WIN(WIN), .CNT_W(CNT_W)) u_chk (
  .clk(ref_clk), .rst_n(rst_n), .en_q(en_q), .ien_q(ien_q), .stable(stable),
  .win(win), .ready(ready), .irq(irq), .freq_q(freq_q)
);

// File: tb/xosc_ctrl_tb.sv
`timescale 1ns/1ps
module xosc_ctrl_tb;
  logic ref_clk = 1'b0;
  logic m4 = 1'b0, m10 = 1'b0, sel10 = 1'b0;
  logic main_clk;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 ref_clk = ~ref_clk;
  initial begin #1; forever #2 m4 = ~m4; end
  initial begin #2; forever #5 m10 = ~m10; end
  assign main_clk = sel10 ? m10 : m4;

  xosc_ctrl u_dut (
    .ref_clk(ref_clk), .main_clk(main_clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge ref_clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl(input bit en, input int units);
    return {16'd0, 8'(units), 7'd0, en};
  endfunction

  // after the stable edge: ready low for 17 edges, then within 8
  task automatic wait_ready(input string req, output int cnt);
    logic [31:0] d;
    int n = 0;
    repeat (17) @(negedge ref_clk);
    rd(2'd3, d);
    check(d[16] == 1'b0, {req, " R5 ready early"}, d[16], 0);
    check(d[15:0] == 0, {req, " R7 count hidden"}, d[15:0], 0);
    while (d[16] == 1'b0 && n < 8) begin
      @(negedge ref_clk); n++; rd(2'd3, d);
    end
    check(d[16] == 1'b1, {req, " R5 ready due"}, d[16], 1);
    cnt = d[15:0];
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 0, "R1 reset register", d, 0);
    end
    check(irq == 1'b0, "R1 reset irq", irq, 0);
  endtask

  task automatic t_seven();
    logic [31:0] d;
    int c;
    wr(2'd0, ctrl(1, 7));
    repeat (55) @(negedge ref_clk);
    rd(2'd2, d);
    check(d[0] == 1'b0, "R2 not stable at 55", d[0], 0);
    @(negedge ref_clk);
    rd(2'd2, d);
    check(d[0] == 1'b1, "R2 stable at 56", d[0], 1);
    check(irq == 1'b0, "R4 masked irq", irq, 0);
    wait_ready("R6 4ns", c);
    check(c == 80, "R6 count 4ns", c, 80);
    wr(2'd1, 32'd1);
    check(irq == 1'b1, "R4 irq enabled", irq, 1);
    wr(2'd0, ctrl(1, 3));
    rd(2'd3, d);
    check(d[16] == 1'b1 && d[15:0] == 80, "R9 no restart", d[15:0], 80);
    rd(2'd2, d);
    check(d[1:0] == 2'b11, "R9 flags kept", d[1:0], 3);
    rd(2'd0, d);
    check(d == ctrl(1, 3), "R10 ctrl readback", d, ctrl(1, 3));
    rd(2'd1, d);
    check(d == 1, "R10 ien readback", d, 1);
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h0);
    rd(2'd3, d);
    check(d == 32'h10050, "R10 read-only ignored", d, 32'h10050);
    wr(2'd0, ctrl(0, 3));
    rd(2'd2, d);
    check(d[1:0] == 2'b00, "R8 flags cleared", d[1:0], 0);
    rd(2'd3, d);
    check(d == 0, "R8 count cleared", d, 0);
    check(irq == 1'b0, "R4 irq drops", irq, 0);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    int c;
    sel10 = 1'b1;
    @(negedge ref_clk);
    wr(2'd0, ctrl(1, 0));
    rd(2'd2, d);
    check(d[0] == 1'b0, "R3 not stable at write", d[0], 0);
    @(negedge ref_clk);
    rd(2'd2, d);
    check(d[0] == 1'b1, "R3 stable after one", d[0], 1);
    check(irq == 1'b1, "R4 irq with stable", irq, 1);
    wait_ready("R6 10ns", c);
    check(c == 32, "R6 count 10ns", c, 32);
    wr(2'd0, ctrl(0, 0));
  endtask

  task automatic t_abort();
    logic [31:0] d;
    int c;
    wr(2'd0, ctrl(1, 2));
    repeat (22) @(negedge ref_clk);
    wr(2'd0, ctrl(0, 2));
    rd(2'd2, d);
    check(d[1:0] == 2'b00, "R8 abort clears", d[1:0], 0);
    wr(2'd0, ctrl(1, 1));
    repeat (7) @(negedge ref_clk);
    rd(2'd2, d);
    check(d[0] == 1'b0, "R8 fresh startup early", d[0], 0);
    @(negedge ref_clk);
    rd(2'd2, d);
    check(d[0] == 1'b1, "R8 fresh startup due", d[0], 1);
    wait_ready("R8 remeasure", c);
    check(c == 32, "R8 fresh count", c, 32);
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge ref_clk);
    t_seven();
    t_zero();
    t_abort();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule